// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit computes quotients and remainders for a 64-bit integer core. It handles signed and unsigned division and remainder on full-width operands. In word mode it handles the same four operations on the low 32 bits of each operand. A caller puts the operands on `a` and `b`, the operation on `op` and the width on `word`, then raises `start` for one cycle. The unit answers on `result` with a one-cycle `done` pulse.

Normal operations go through a restoring shift-subtract loop on operand magnitudes. The loop produces one quotient bit per cycle, and the signs are applied in one final cycle. Three cases skip the loop and come back on the next cycle: a zero divisor, the signed overflow case (most negative value divided by minus one) and an operation code that is not a divide. None of these cases raises an exception; each returns a fixed value.

The controller has four states. IDLE waits for `start`. RUN performs one quotient step per cycle. FIX applies the signs and the width. DONE raises `done` for one cycle. The transitions are:
- start-normal: IDLE to RUN.
- start-special: IDLE to DONE.
- last-step: RUN to FIX, after 64 steps, or 32 in word mode.
- finish: FIX to DONE.
- release: DONE to IDLE.

Top module: `intdiv_unit`

## Requirements
- R1: `op[1:0]` selects the operation: 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder. `op[2]` must be 1 for these operations.
- R2: A signed quotient truncates toward zero. A nonzero signed remainder has the sign of the dividend, for example -7/2 gives -3 remainder -1.
- R3: With a zero divisor, both quotient operations return all ones and both remainder operations return the dividend.
- R4: In the signed overflow case, the quotient is the most negative value and the remainder is 0.
- R5: With `word`=1, only bits 31:0 of `a` and `b` are used. Signed operations sign-extend them and unsigned operations zero-extend them. The zero-divisor and overflow rules apply at 32-bit width, and every word result is bit 31 sign-extended to 64 bits.
- R6: A normal operation raises `done` 66 clock edges after the edge that accepts `start`, or 34 edges in word mode.
- R7: A zero divisor or signed overflow raises `done` one edge after the accepting edge.
- R8: `busy` goes high on the edge after an accepted `start` and stays high through the `done` cycle. A `start` while `busy` is high is ignored.
- R9: `done` lasts one cycle. `result` holds its value from `done` until the next accepted `start`.
- R10: If `op[2]` is 0, the unit returns 0 with `done` one edge after the accepting edge.
- R11: After reset, `busy` and `done` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation, taken only when not busy |
| op | input | 3 | Operation code: bit 2 enables, bit 1 selects remainder, bit 0 selects unsigned |
| word | input | 1 | 32-bit word mode |
| a | input | 64 | Dividend |
| b | input | 64 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 64 | Quotient or remainder |

## Verification
A wrong step counter shows up as `done` on the wrong edge, so every operation checks its latency as well as its value. A bad partial remainder or a bad quotient bit ruins the final value, and a sign handled wrongly in FIX shows up only on mixed-sign operands. Directed cases with mixed signs and edge values catch both, and a batch of pseudo-random operands follows them. A controller that accepts `start` while busy replaces the value in flight and raises `done` again, so the bench checks both right after the ignored pulse.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX,
        ST_DONE
    } dv_state_e;

    typedef struct packed {
        logic is_rem;
        logic is_uns;
        logic word;
        logic neg_q;
        logic neg_r;
    } dv_ctl_t;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]      op,
    input  logic            word,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] mag_a,
    output logic [XLEN-1:0] mag_b,
    output dv_ctl_t         ctl,
    output logic            special,
    output logic [XLEN-1:0] spec_res
);
    localparam int HALF = XLEN / 2;

    logic            uns;
    logic            rem_op;
    logic [XLEN-1:0] a_x;
    logic [XLEN-1:0] b_x;
    logic            sgn_a;
    logic            sgn_b;
    logic [XLEN-1:0] min_v;
    logic            b_zero;
    logic            ovf;
    logic [XLEN-1:0] raw;

    assign uns    = op[0];
    assign rem_op = op[1];

    // operand extension for word mode
    always_comb begin
        if (word) begin
            a_x = uns ? {{HALF{1'b0}}, a[HALF-1:0]} : {{HALF{a[HALF-1]}}, a[HALF-1:0]};
            b_x = uns ? {{HALF{1'b0}}, b[HALF-1:0]} : {{HALF{b[HALF-1]}}, b[HALF-1:0]};
            min_v = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
        end else begin
            a_x   = a;
            b_x   = b;
            min_v = {1'b1, {(XLEN-1){1'b0}}};
        end
    end

    assign sgn_a  = !uns && a_x[XLEN-1];
    assign sgn_b  = !uns && b_x[XLEN-1];
    assign mag_a  = sgn_a ? (~a_x + 1'b1) : a_x;
    assign mag_b  = sgn_b ? (~b_x + 1'b1) : b_x;
    assign b_zero = (b_x == '0);
    assign ovf    = !uns && (a_x == min_v) && (b_x == '1);

    assign special = !op[2] || b_zero || ovf;

    always_comb begin
        if (!op[2])      raw = '0;
        else if (b_zero) raw = rem_op ? a_x : '1;
        else if (ovf)    raw = rem_op ? '0 : a_x;
        else             raw = '0;
    end

    assign spec_res = word ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;

    always_comb begin
        ctl.is_rem = rem_op;
        ctl.is_uns = uns;
        ctl.word   = word;
        ctl.neg_q  = sgn_a ^ sgn_b;
        ctl.neg_r  = sgn_a;
    end
endmodule

// File: rtl/intdiv_step.sv
module intdiv_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] dsr,
    output logic [XLEN-1:0] rem_n,
    output logic [XLEN-1:0] quo_n
);
    logic [XLEN:0] trial;
    logic [XLEN:0] diff;
    logic          fits;

    assign trial = {rem, quo[XLEN-1]};
    assign diff  = trial - {1'b0, dsr};
    assign fits  = !diff[XLEN];
    assign rem_n = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
    assign quo_n = {quo[XLEN-2:0], fits};
endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic            word,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(XLEN - 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(HALF - 1);

    dv_state_e       state_q, state_d;
    dv_ctl_t         ctl_q, ctl_in;
    logic [CNT_W-1:0] cnt_q;
    logic [XLEN-1:0] rem_q, quo_q, dsr_q, result_q;
    logic [XLEN-1:0] mag_a, mag_b, spec_res;
    logic [XLEN-1:0] rem_n, quo_n;
    logic            special;
    logic            accept;
    logic            last_step;
    logic [XLEN-1:0] sel;

    intdiv_prep #(.XLEN(XLEN)) u_prep (
        .op       (op),
        .word     (word),
        .a        (a),
        .b        (b),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .ctl      (ctl_in),
        .special  (special),
        .spec_res (spec_res)
    );

    intdiv_step #(.XLEN(XLEN)) u_step (
        .rem   (rem_q),
        .quo   (quo_q),
        .dsr   (dsr_q),
        .rem_n (rem_n),
        .quo_n (quo_n)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_step = (cnt_q == (ctl_q.word ? LAST_WORD : LAST_FULL));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = special ? ST_DONE : ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sign and width fix-up of the loop outcome
    always_comb begin
        if (ctl_q.is_rem) sel = ctl_q.neg_r ? (~rem_q + 1'b1) : rem_q;
        else              sel = ctl_q.neg_q ? (~quo_q + 1'b1) : quo_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            cnt_q    <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            dsr_q    <= '0;
            result_q <= '0;
        end else begin
            if (accept) begin
                ctl_q <= ctl_in;
                cnt_q <= '0;
                rem_q <= '0;
                dsr_q <= mag_b;
                quo_q <= word ? {mag_a[HALF-1:0], {HALF{1'b0}}} : mag_a;
                if (special) result_q <= spec_res;
            end else if (state_q == ST_RUN) begin
                rem_q <= rem_n;
                quo_q <= quo_n;
                cnt_q <= cnt_q + 1'b1;
            end else if (state_q == ST_FIX) begin
                result_q <= ctl_q.word ? {{HALF{sel[HALF-1]}}, sel[HALF-1:0]} : sel;
            end
        end
    end

    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        result = result_q;
    end
endmodule

// File: rtl/intdiv_unit_chk.sv
module intdiv_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2:0]      op,
    input logic            word,
    input logic [XLEN-1:0] a,
    input logic [XLEN-1:0] b,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result
);
    localparam int HALF = XLEN / 2;

    logic zero_div;
    assign zero_div = word ? (b[HALF-1:0] == '0) : (b == '0);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(result));

    // R7
    zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op[2] && zero_div) |=> done);

    // R10
    illegal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op[2]) |=> (done && result == '0));
endmodule

bind intdiv_unit intdiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .word   (word),
    .a      (a),
    .b      (b),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/intdiv_unit_tb.sv
module intdiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b100;
    logic        word = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        busy, done;
    logic [63:0] result;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [2:0] OP_DIV  = 3'b100;
    localparam logic [2:0] OP_DIVU = 3'b101;
    localparam logic [2:0] OP_REM  = 3'b110;
    localparam logic [2:0] OP_REMU = 3'b111;
    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

    intdiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
        .a(a), .b(b), .busy(busy), .done(done), .result(result)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [2:0] o, input logic w,
                                          input logic [63:0] x, input logic [63:0] y,
                                          output logic spec);
        longint sa, sb, smin;
        logic [63:0] ua, ub, r;
        if (w) begin
            sa = longint'($signed(x[31:0])); sb = longint'($signed(y[31:0]));
            ua = {32'b0, x[31:0]};           ub = {32'b0, y[31:0]};
            smin = -64'sd2147483648;
        end else begin
            sa = x; sb = y; ua = x; ub = y;
            smin = MINV;
        end
        spec = 1'b0;
        if (!o[2]) begin
            spec = 1'b1; r = '0;
        end else if (o[0]) begin
            if (ub == 0) begin spec = 1'b1; r = o[1] ? ua : '1; end
            else r = o[1] ? ua % ub : ua / ub;
        end else begin
            if (sb == 0) begin spec = 1'b1; r = o[1] ? sa : -1; end
            else if (sb == -1 && sa == smin) begin spec = 1'b1; r = o[1] ? 64'd0 : sa; end
            else r = o[1] ? sa % sb : sa / sb;
        end
        if (w) r = {{32{r[31]}}, r[31:0]};
        return r;
    endfunction

    // one operation: value plus latency
    task automatic run_op(input logic [2:0] o, input logic w, input logic [63:0] x,
                          input logic [63:0] y, input string tag);
        logic [63:0] exp;
        logic spec;
        int k, lat;
        exp = model(o, w, x, y, spec);
        lat = spec ? 1 : (w ? 34 : 66);
        @(negedge clk);
        op = o; word = w; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 200) begin @(negedge clk); k++; end
        check({tag, " value"}, result, exp);
        check(spec ? "R7 latency" : "R6 latency", 64'(k), 64'(lat));
    endtask

    task automatic t_reset;
        check("R11 busy", 64'(busy), 64'd0);
        check("R11 done", 64'(done), 64'd0);
        check("R11 result", result, 64'd0);
    endtask

    task automatic t_basic;
        run_op(OP_DIVU, 0, 64'd1000, 64'd7, "R1 divu");
        run_op(OP_REMU, 0, 64'd1000, 64'd7, "R1 remu");
        run_op(OP_DIVU, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R1 divu max");
        run_op(OP_DIV, 0, 64'd100, 64'd9, "R1 div");
        run_op(OP_REM, 0, 64'd100, 64'd9, "R1 rem");
        run_op(OP_DIVU, 0, 64'd5, 64'd9, "R1 small");
    endtask

    task automatic t_signs;
        run_op(OP_DIV, 0, -64'sd7, 64'sd2, "R2 -7/2");
        run_op(OP_REM, 0, -64'sd7, 64'sd2, "R2 -7%2");
        run_op(OP_DIV, 0, 64'sd7, -64'sd2, "R2 7/-2");
        run_op(OP_REM, 0, 64'sd7, -64'sd2, "R2 7%-2");
        run_op(OP_DIV, 0, -64'sd7, -64'sd2, "R2 -7/-2");
        run_op(OP_REM, 0, -64'sd7, -64'sd2, "R2 -7%-2");
        run_op(OP_DIV, 0, MINV, 64'sd2, "R2 min/2");
    endtask

    task automatic t_zero;
        run_op(OP_DIV, 0, 64'd1234, 64'd0, "R3 div0");
        run_op(OP_DIVU, 0, 64'd1234, 64'd0, "R3 divu0");
        run_op(OP_REM, 0, -64'sd55, 64'd0, "R3 rem0");
        run_op(OP_REMU, 0, 64'hDEAD_BEEF_0000_0001, 64'd0, "R3 remu0");
    endtask

    task automatic t_ovf;
        run_op(OP_DIV, 0, MINV, '1, "R4 div ovf");
        run_op(OP_REM, 0, MINV, '1, "R4 rem ovf");
    endtask

    task automatic t_word;
        run_op(OP_DIV, 1, 64'h1234_5678_FFFF_FFF9, 64'hAAAA_0000_0000_0002, "R5 divw");
        run_op(OP_REM, 1, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, "R5 remw");
        run_op(OP_DIVU, 1, 64'hFFFF_0000_FFFF_FFF0, 64'h0000_0001_0000_0001, "R5 divuw");
        run_op(OP_REMU, 1, 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_8000_0001, "R5 remuw sext");
        run_op(OP_DIV, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 divw ovf");
        run_op(OP_REM, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 remw ovf");
        run_op(OP_DIVU, 1, 64'h5, 64'hFFFF_FFFF_0000_0000, "R5 divuw zero");
        run_op(OP_REMU, 1, 64'h0000_0000_8000_0005, 64'h1_0000_0000, "R5 remuw zero");
    endtask

    task automatic t_illegal;
        run_op(3'b000, 0, 64'd77, 64'd3, "R10 op000");
        run_op(3'b011, 1, 64'd77, 64'd0, "R10 op011");
    endtask

    task automatic t_ignore;
        logic [63:0] exp;
        logic spec;
        exp = model(OP_DIVU, 0, 64'd999_999, 64'd13, spec);
        @(negedge clk);
        op = OP_DIVU; word = 0; a = 64'd999_999; b = 64'd13; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 busy during run", 64'(busy), 64'd1);
        op = OP_REM; a = 64'd5; b = 64'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 no early done", 64'(done), 64'd0);
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        check("R8 result kept", result, exp);
        @(negedge clk);
        check("R9 done one cycle", 64'(done), 64'd0);
        check("R8 no second run", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        check("R9 result held", result, exp);
    endtask

    task automatic t_random;
        logic [63:0] s;
        logic [63:0] x, y;
        s = 64'h1234_5678_9ABC_DEF1;
        for (int i = 0; i < 48; i++) begin
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            x = s;
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            y = (i % 3 == 0) ? (s >> (s[5:0])) : s;
            run_op({1'b1, s[1:0]}, s[2], x, y, (s[1] ? "R1 R2 R5 rand rem" : "R1 R2 R5 rand div"));
        end
    endtask

    initial begin
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_signs();
        t_zero();
        t_ovf();
        t_word();
        t_illegal();
        t_ignore();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule